// File: doc/BRIEF.md
# Pulse-per-second time counter generator

This block keeps time for a chip running from a fixed reference clock (125 MHz by default). It holds a sub-second counter that counts reference cycles, so each step is one reference period rather than one nanosecond. It also holds a 40-bit count of whole seconds. The sub-second counter wraps once per second and each wrap adds one to the seconds count. The seconds value is a simple running total: it is not calendar time and it knows nothing about leap seconds. Each natural second boundary starts a pulse of programmable length on the pulse-per-second output. A separate valid bit can hold that output low.

Software uses a small word-wide register port. It writes a target time or a signed correction into staged registers, then issues a self-clearing command. The command either loads the staged values as an absolute time or adds them to the live counters as offsets, in one step. Software reads the time through a snapshot, so the seconds and cycle words it sees always belong to the same instant.

Top module: `pps_gen`

## Requirements
- R1: After reset the counters are zero, counting is stopped, the valid bit is clear, the pulse width equals the DEF_WIDTH parameter and pps_out is low.
- R2: While the run bit is set and no command is applied, the cycle counter advances by one per clock from 0 to CYC_PER_SEC-1 and then returns to 0 while the seconds count rises by one. With the run bit clear, both counters hold.
- R3: The seconds count is SEC_W bits wide (40 by default) and wraps from all ones to zero on a rollover.
- R4: Register map, by word address. 0 is control: bit 0 run, bit 1 set command, bit 2 adjust command, bits 31:4 pulse width in cycles. 1 holds the output valid bit in bit 0. 2 and 3 are the staged seconds, low 32 bits and high SEC_W-32 bits. 4 is the staged cycle value, 32-bit two's complement. 5, 6 and 7 read the live seconds low word, the seconds high word and the cycle count. Staged and control words read back as written.
- R5: A set command is applied on the clock edge that follows the edge capturing the write. It loads the staged seconds and cycle values as an absolute time. A staged cycle value of CYC_PER_SEC or more loads 0.
- R6: An adjust command is applied on the same edge as a set would be. It adds the staged seconds (two's complement) and the staged cycle value (signed, magnitude below CYC_PER_SEC) to the live time. The adjustment includes that cycle's normal tick when running. A cycle result below zero borrows one second; a result of CYC_PER_SEC or more carries one second.
- R7: Control bit 2 reads 1 in the cycle after the adjust write and 0 once the adjustment has been applied.
- R8: When set and adjust are written together, only the set takes effect.
- R9: A rollover produced by counting (not by set or adjust) drives pps_out high. The rise comes one cycle after the seconds count increments, and the output stays high for the programmed width in cycles. A width of 0 gives no pulse.
- R10: While the valid bit is clear, pps_out is low from the next cycle on.
- R11: Reading address 5 latches the seconds high word and the cycle count into a snapshot. Addresses 6 and 7 return that snapshot until the next read of address 5.
- R12: The cycle counter never holds a value of CYC_PER_SEC or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (takes the snapshot on address 5) |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| pps_out | output | 1 | Pulse-per-second output |

## Verification
Two pairs of functions can land on the same edge. The first pair is set and adjust, issued by one control write with both bits set. The bench checks that the result is exactly the staged absolute time, with no offset added. The second pair is an adjustment and a normal counting tick. The bench writes the run bit and the adjust bit in one word, then reads back the cycle count. A correct result equals the start value plus the offset plus one tick for each edge on which the counter was running. Directed adjust cases push the cycle sum below zero and past one second, to confirm the single borrow or carry into the seconds count.

// File: rtl/pps_pkg.sv
package pps_pkg;
   localparam int REG_W      = 32;
   localparam int ADDR_W     = 3;
   localparam int CTRL_RUN   = 0;
   localparam int CTRL_SET   = 1;
   localparam int CTRL_ADJ   = 2;
   localparam int CTRL_PW_LO = 4;
   localparam int PW_W       = REG_W - CTRL_PW_LO;

   localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_OUTEN   = 3'd1;
   localparam logic [ADDR_W-1:0] A_STG_SLO = 3'd2;
   localparam logic [ADDR_W-1:0] A_STG_SHI = 3'd3;
   localparam logic [ADDR_W-1:0] A_STG_CYC = 3'd4;
   localparam logic [ADDR_W-1:0] A_LIV_SLO = 3'd5;
   localparam logic [ADDR_W-1:0] A_LIV_SHI = 3'd6;
   localparam logic [ADDR_W-1:0] A_LIV_CYC = 3'd7;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
   import pps_pkg::*;
#(
   parameter int CYC_PER_SEC = 125000000,
   parameter int SEC_W       = 40,
   parameter int DEF_WIDTH   = 100000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [REG_W-1:0]        wr_data,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [REG_W-1:0]        rd_data,
   input  logic [SEC_W-1:0]        live_sec,
   input  logic [$clog2(CYC_PER_SEC)-1:0] live_cyc,
   output logic                    run,
   output logic                    set_pend,
   output logic                    adj_pend,
   output logic [PW_W-1:0]         width,
   output logic                    out_valid,
   output logic [SEC_W-1:0]        stg_sec,
   output logic signed [REG_W-1:0] stg_cyc
);
   localparam int CYC_W = $clog2(CYC_PER_SEC);
   localparam int SHI_W = SEC_W - REG_W;

   logic [SHI_W-1:0] snap_shi;
   logic [CYC_W-1:0] snap_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         set_pend  <= 1'b0;
         adj_pend  <= 1'b0;
         width     <= PW_W'(DEF_WIDTH);
         out_valid <= 1'b0;
         stg_sec   <= '0;
         stg_cyc   <= '0;
         snap_shi  <= '0;
         snap_cyc  <= '0;
      end else begin
         set_pend <= 1'b0;
         adj_pend <= 1'b0;
         if (wr_en) begin
            case (wr_addr)
               A_CTRL: begin
                  run      <= wr_data[CTRL_RUN];
                  set_pend <= wr_data[CTRL_SET];
                  adj_pend <= wr_data[CTRL_ADJ];
                  width    <= wr_data[REG_W-1:CTRL_PW_LO];
               end
               A_OUTEN:   out_valid             <= wr_data[0];
               A_STG_SLO: stg_sec[REG_W-1:0]    <= wr_data;
               A_STG_SHI: stg_sec[SEC_W-1:REG_W] <= wr_data[SHI_W-1:0];
               A_STG_CYC: stg_cyc               <= wr_data;
               default: ;
            endcase
         end
         if (rd_en && rd_addr == A_LIV_SLO) begin
            snap_shi <= live_sec[SEC_W-1:REG_W];
            snap_cyc <= live_cyc;
         end
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:    rd_data = {width, 1'b0, adj_pend, set_pend, run};
         A_OUTEN:   rd_data = REG_W'(out_valid);
         A_STG_SLO: rd_data = stg_sec[REG_W-1:0];
         A_STG_SHI: rd_data = REG_W'(stg_sec[SEC_W-1:REG_W]);
         A_STG_CYC: rd_data = stg_cyc;
         A_LIV_SLO: rd_data = live_sec[REG_W-1:0];
         A_LIV_SHI: rd_data = REG_W'(snap_shi);
         default:   rd_data = REG_W'(snap_cyc);
      endcase
   end
endmodule

// File: rtl/pps_counter.sv
module pps_counter #(
   parameter int CYC_PER_SEC = 125000000,
   parameter int SEC_W       = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    set_pend,
   input  logic                    adj_pend,
   input  logic [SEC_W-1:0]        stg_sec,
   input  logic signed [31:0]      stg_cyc,
   output logic [SEC_W-1:0]        sec,
   output logic [$clog2(CYC_PER_SEC)-1:0] cyc,
   output logic                    rollover
);
   localparam int CYC_W = $clog2(CYC_PER_SEC);
   localparam int SUM_W = 34;
   localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_PER_SEC - 1);
   localparam logic signed [SUM_W-1:0] LIM_S = SUM_W'(CYC_PER_SEC);

   logic signed [SUM_W-1:0] base_s, sum_s;
   logic [CYC_W-1:0]        adj_cyc, set_cyc;
   logic [SEC_W-1:0]        sec_carry;

   // Adjust path: current count plus this cycle's tick plus signed offset,
   // folded back into range with at most one carry or borrow.
   always_comb begin
      base_s = SUM_W'(cyc) + SUM_W'(run);
      sum_s  = base_s + SUM_W'(stg_cyc);
      if (sum_s < 0) begin
         adj_cyc   = CYC_W'(sum_s + LIM_S);
         sec_carry = '1;
      end else if (sum_s >= LIM_S) begin
         adj_cyc   = CYC_W'(sum_s - LIM_S);
         sec_carry = SEC_W'(1);
      end else begin
         adj_cyc   = CYC_W'(sum_s);
         sec_carry = '0;
      end
      set_cyc = ($unsigned(stg_cyc) >= 32'(CYC_PER_SEC)) ? '0 : CYC_W'(stg_cyc);
   end

   assign rollover = run && !set_pend && !adj_pend && (cyc == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec <= '0;
         cyc <= '0;
      end else if (set_pend) begin
         sec <= stg_sec;
         cyc <= set_cyc;
      end else if (adj_pend) begin
         sec <= sec + stg_sec + sec_carry;
         cyc <= adj_cyc;
      end else if (run) begin
         if (cyc == LAST) begin
            cyc <= '0;
            sec <= sec + SEC_W'(1);
         end else begin
            cyc <= cyc + CYC_W'(1);
         end
      end
   end
endmodule

// File: rtl/pps_pulse.sv
module pps_pulse #(
   parameter int PW_W    = 28,
   parameter int OUT_REG = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig,
   input  logic [PW_W-1:0] width,
   input  logic            valid,
   output logic            pps_out
);
   logic [PW_W-1:0] pw_cnt;
   logic            active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pw_cnt <= '0;
      else if (trig)          pw_cnt <= width;
      else if (pw_cnt != '0)  pw_cnt <= pw_cnt - PW_W'(1);
   end

   assign active = (pw_cnt != '0);

   generate
      if (OUT_REG != 0) begin : g_reg
         logic pps_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pps_q <= 1'b0;
            else        pps_q <= valid && active;
         end
         assign pps_out = pps_q;
      end else begin : g_comb
         assign pps_out = valid && active;
      end
   endgenerate
endmodule

// File: rtl/pps_gen.sv
module pps_gen
   import pps_pkg::*;
#(
   parameter int CYC_PER_SEC = 125000000,
   parameter int SEC_W       = 40,
   parameter int DEF_WIDTH   = 100000,
   parameter int OUT_REG     = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic        rd_en,
   input  logic [2:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        pps_out
);
   localparam int CYC_W = $clog2(CYC_PER_SEC);

   generate
      if (CYC_PER_SEC < 2 || CYC_W > 30) begin : g_bad_cps
         $error("CYC_PER_SEC out of supported range");
      end
      if (SEC_W < 33 || SEC_W > 64) begin : g_bad_secw
         $error("SEC_W must lie in 33..64");
      end
      if (DEF_WIDTH < 0 || DEF_WIDTH > (1 << PW_W) - 1) begin : g_bad_width
         $error("DEF_WIDTH does not fit the width field");
      end
      if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_outreg
         $error("OUT_REG must be 0 or 1");
      end
   endgenerate

   logic                    run, set_pend, adj_pend, out_valid, rollover;
   logic [PW_W-1:0]         width;
   logic [SEC_W-1:0]        stg_sec, sec;
   logic signed [REG_W-1:0] stg_cyc;
   logic [CYC_W-1:0]        cyc;

   pps_regs #(
      .CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W), .DEF_WIDTH(DEF_WIDTH)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .live_sec(sec), .live_cyc(cyc),
      .run(run), .set_pend(set_pend), .adj_pend(adj_pend),
      .width(width), .out_valid(out_valid),
      .stg_sec(stg_sec), .stg_cyc(stg_cyc)
   );

   pps_counter #(
      .CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .run(run), .set_pend(set_pend), .adj_pend(adj_pend),
      .stg_sec(stg_sec), .stg_cyc(stg_cyc),
      .sec(sec), .cyc(cyc), .rollover(rollover)
   );

   pps_pulse #(
      .PW_W(PW_W), .OUT_REG(OUT_REG)
   ) u_pulse (
      .clk(clk), .rst_n(rst_n),
      .trig(rollover), .width(width), .valid(out_valid),
      .pps_out(pps_out)
   );
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
   parameter int CYC_PER_SEC = 125000000,
   parameter int SEC_W       = 40,
   parameter int OUT_REG     = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    run,
   input logic                    set_pend,
   input logic                    adj_pend,
   input logic                    adj_wr,
   input logic                    out_valid,
   input logic                    pps_out,
   input logic [SEC_W-1:0]        stg_sec,
   input logic [SEC_W-1:0]        sec,
   input logic [$clog2(CYC_PER_SEC)-1:0] cyc
);
   localparam int CYC_W = $clog2(CYC_PER_SEC);
   localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_PER_SEC - 1);

   AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cyc) < CYC_PER_SEC); // R12

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !set_pend && !adj_pend) |=> ($stable(cyc) && $stable(sec))); // R2

   AST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !set_pend && !adj_pend && cyc != LAST)
      |=> (cyc == $past(cyc) + CYC_W'(1) && $stable(sec))); // R2

   AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !set_pend && !adj_pend && cyc == LAST)
      |=> (cyc == '0 && sec == $past(sec) + SEC_W'(1))); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |=> (sec == $past(stg_sec))); // R8

   AST_ADJ_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_pend && !adj_wr) |=> !adj_pend); // R7

   generate
      if (OUT_REG != 0) begin : g_reg
         AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |=> !pps_out); // R10
      end else begin : g_comb
         AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> !pps_out); // R10
      end
   endgenerate
endmodule

bind pps_gen pps_chk #(
   .CYC_PER_SEC(CYC_PER_SEC), .SEC_W(SEC_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .run(run), .set_pend(set_pend), .adj_pend(adj_pend),
   .adj_wr(wr_en && wr_addr == 3'd0 && wr_data[2]),
   .out_valid(out_valid), .pps_out(pps_out),
   .stg_sec(stg_sec), .sec(sec), .cyc(cyc)
);

// File: tb/pps_gen_test.sv
module pps_gen_test;
   localparam int CPS = 1000;
   localparam int W   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        pps_out;

   int n_chk = 0;
   int n_fail = 0;
   int hi_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pps_gen #(.CYC_PER_SEC(CPS), .DEF_WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pps_out(pps_out)
   );

   always @(negedge clk) if (pps_out === 1'b1) hi_cnt++;

   function automatic logic [31:0] ctl(bit run, bit set, bit adj, int width);
      return {28'(width), 1'b0, adj, set, run};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic measure(input int n, output int highs);
      int start;
      @(negedge clk); #2 start = hi_cnt;
      repeat (n) @(negedge clk);
      #2 highs = hi_cnt - start;
   endtask

   task automatic stage(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] c);
      wr(3'd2, lo); wr(3'd3, hi); wr(3'd4, c);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 pps_out low", 32'(pps_out), 32'd0);
      rd(3'd0, d); chk("R1 control reset", d, ctl(0, 0, 0, W));
      rd(3'd1, d); chk("R1 valid reset", d, 32'd0);
      rd(3'd5, d); chk("R1 seconds reset", d, 32'd0);
      rd(3'd7, d); chk("R1 cycles reset", d, 32'd0);
      wr(3'd4, 32'h0000_0123);
      rd(3'd4, d); chk("R4 staged cycle readback", d, 32'h0000_0123);
   endtask

   task automatic t_set_stopped;
      logic [31:0] d;
      stage(32'h3456_789A, 32'h12, 32'd500);
      wr(3'd0, ctl(0, 1, 0, W));
      rd(3'd5, d); chk("R5 set seconds low", d, 32'h3456_789A);
      rd(3'd6, d); chk("R5 set seconds high", d, 32'h12);
      rd(3'd7, d); chk("R5 set cycles", d, 32'd500);
      repeat (20) @(negedge clk);
      rd(3'd5, d); chk("R2 hold seconds while stopped", d, 32'h3456_789A);
      rd(3'd7, d); chk("R2 hold cycles while stopped", d, 32'd500);
      wr(3'd4, 32'd1000);
      wr(3'd0, ctl(0, 1, 0, W));
      rd(3'd5, d);
      rd(3'd7, d); chk("R5 out of range cycle loads 0", d, 32'd0);
      wr(3'd4, 32'd500);
      wr(3'd0, ctl(0, 1, 0, W));
   endtask

   task automatic t_adj_pending;
      logic [31:0] d;
      stage(32'd0, 32'd0, 32'd0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = ctl(0, 0, 1, W);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b1; rd_addr = 3'd0;
      #1 chk("R7 adjust bit pending", 32'(rd_data[2]), 32'd1);
      @(negedge clk);
      #1 chk("R7 adjust bit cleared", 32'(rd_data[2]), 32'd0);
      rd_en = 1'b0;
      rd(3'd5, d); chk("R6 zero adjust keeps seconds", d, 32'h3456_789A);
      rd(3'd7, d); chk("R6 zero adjust keeps cycles", d, 32'd500);
   endtask

   task automatic t_adj_offsets;
      logic [31:0] d;
      stage(32'd1, 32'd0, 32'd600);
      wr(3'd0, ctl(0, 0, 1, W));
      rd(3'd5, d); chk("R6 carry seconds", d, 32'h3456_789C);
      rd(3'd7, d); chk("R6 carry cycles", d, 32'd100);
      stage(32'd0, 32'd0, 32'hFFFF_FED4);
      wr(3'd0, ctl(0, 0, 1, W));
      rd(3'd5, d); chk("R6 borrow seconds", d, 32'h3456_789B);
      rd(3'd7, d); chk("R12 borrow cycles in range", d, 32'd800);
      stage(32'hFFFF_FFFB, 32'hFF, 32'd0);
      wr(3'd0, ctl(0, 0, 1, W));
      rd(3'd5, d); chk("R6 negative seconds low", d, 32'h3456_7896);
      rd(3'd6, d); chk("R6 negative seconds high", d, 32'h12);
   endtask

   task automatic t_set_and_adj;
      logic [31:0] d;
      stage(32'h0000_0100, 32'h01, 32'd42);
      wr(3'd0, ctl(0, 1, 1, W));
      rd(3'd5, d); chk("R8 set wins seconds low", d, 32'h0000_0100);
      rd(3'd6, d); chk("R8 set wins seconds high", d, 32'h01);
      rd(3'd7, d); chk("R8 set wins cycles", d, 32'd42);
   endtask

   task automatic t_adj_running;
      logic [31:0] d;
      stage(32'd0, 32'd0, 32'd77);
      wr(3'd0, ctl(0, 1, 0, W));
      wr(3'd4, 32'd50);
      wr(3'd0, ctl(1, 0, 1, W));
      wr(3'd0, ctl(0, 0, 0, W));
      rd(3'd5, d); chk("R6 running adjust seconds", d, 32'd0);
      rd(3'd7, d); chk("R6 running adjust includes tick", d, 32'd129);
   endtask

   task automatic t_rollover_pulse;
      logic [31:0] d;
      int highs;
      int guard;
      wr(3'd1, 32'd1);
      stage(32'd7, 32'd0, 32'd990);
      wr(3'd0, ctl(0, 1, 0, W));
      wr(3'd0, ctl(1, 0, 0, W));
      guard = 0;
      while (pps_out !== 1'b1 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk("R9 pulse seen", 32'(pps_out), 32'd1);
      rd_en = 1'b1; rd_addr = 3'd5;
      #1 chk("R2 seconds after rollover", rd_data, 32'd8);
      @(negedge clk);
      rd_en = 1'b0;
      rd(3'd7, d); chk("R9 pulse rises one cycle after rollover", d, 32'd1);
      rd(3'd6, d); chk("R2 seconds high after rollover", d, 32'd0);
      measure(CPS, highs); chk("R9 pulse width", 32'(highs), 32'(W));
   endtask

   task automatic t_valid_and_width;
      int highs;
      wr(3'd1, 32'd0);
      measure(2 * CPS + 100, highs); chk("R10 valid clear holds low", 32'(highs), 32'd0);
      wr(3'd1, 32'd1);
      wr(3'd0, ctl(1, 0, 0, 3));
      measure(CPS, highs);
      measure(CPS, highs); chk("R9 width 3", 32'(highs), 32'd3);
      wr(3'd0, ctl(1, 0, 0, 0));
      measure(CPS, highs);
      measure(CPS, highs); chk("R9 width 0 no pulse", 32'(highs), 32'd0);
      wr(3'd0, ctl(0, 0, 0, W));
   endtask

   task automatic t_sec_wrap;
      logic [31:0] d;
      stage(32'hFFFF_FFFF, 32'hFF, 32'd995);
      wr(3'd0, ctl(0, 1, 0, W));
      wr(3'd0, ctl(1, 0, 0, W));
      repeat (30) @(negedge clk);
      wr(3'd0, ctl(0, 0, 0, W));
      rd(3'd5, d); chk("R3 seconds wrap low", d, 32'd0);
      rd(3'd6, d); chk("R3 seconds wrap high", d, 32'd0);
   endtask

   task automatic t_snapshot;
      logic [31:0] d;
      stage(32'd5, 32'd3, 32'd321);
      wr(3'd0, ctl(0, 1, 0, W));
      rd(3'd5, d); chk("R11 live low", d, 32'd5);
      stage(32'd6, 32'd4, 32'd654);
      wr(3'd0, ctl(0, 1, 0, W));
      rd(3'd6, d); chk("R11 stale snapshot high", d, 32'd3);
      rd(3'd7, d); chk("R11 stale snapshot cycles", d, 32'd321);
      rd(3'd5, d); chk("R11 new live low", d, 32'd6);
      rd(3'd6, d); chk("R11 new snapshot high", d, 32'd4);
      rd(3'd7, d); chk("R11 new snapshot cycles", d, 32'd654);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_stopped();
      t_adj_pending();
      t_adj_offsets();
      t_set_and_adj();
      t_adj_running();
      t_rollover_pulse();
      t_valid_and_width();
      t_sec_wrap();
      t_snapshot();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule